// File: doc/BRIEF.md
# Synchronous Burst Pseudo-Static Memory Port

This block is the device side of a 16-bit pseudo-static memory that works in synchronous burst mode. A host selects the device, presents an address and pulses the address strobe low for one rising clock edge. At that edge the port captures the address and decides between a read burst and a write burst from the write-enable level. It then holds the wait line low while it counts a fixed initial latency, and after that moves four words, one per clock. The storage is a small internal register array that answers to the low address bits only.

The data bus is bidirectional at the pad, so it is split here into an input word, an output word and an output enable. The host may abort a burst at any point by strobing a new address, which restarts the latency count from the new address. It may also end a burst by deselecting the chip. The controller is a three-state machine. The states are IDLE (no burst), DELAY (latency count, wait low) and XFER (data beats). The transitions are: command start (strobe seen while selected: IDLE/DELAY/XFER to DELAY, or straight to XFER if the latency is one clock), latency done (DELAY to XFER), beat advance (XFER to XFER), burst end (fourth beat: XFER to IDLE), restart (a new strobe in any state) and deselect (chip select high in any state: back to IDLE).

Top module: `psram_burst_port`

## Requirements
- R1: A command starts only at a rising edge where cs_n=0 and adv_n=0. we_n=1 at that edge selects a read burst and we_n=0 selects a write burst. A strobe with cs_n=1 starts nothing.
- R2: wait_n (active low) is 0 in every cycle after the command edge until the first data beat, which is LATENCY-1 cycles. It returns to 1 in the cycle where the first beat is presented, and is 1 whenever no latency count is running.
- R3: For a read whose command edge is edge k, the word for beat b (b=0..3) is on dq_out and ready to be sampled at edge k+LATENCY+b.
- R4: For a write whose command edge is edge k, dq_in is stored for beat b at edge k+LATENCY+b.
- R5: The beat address is the captured address with its two low bits replaced by (low bits + b) mod 4, so a burst wraps inside its 4-word aligned group.
- R6: On a write beat, the low byte is stored only if lb_n=0 and the high byte only if ub_n=0. A byte whose enable is high keeps its old value.
- R7: dq_oe is 1 only during a read beat with cs_n=0 and oe_n=0. It is 0 during delay, during write bursts, when idle and when oe_n=1.
- R8: A strobe in the middle of a burst (during delay or transfer) drops the current burst at once, with no store at that edge, and starts the new command with a full latency.
- R9: cs_n=1 at an edge ends any burst with no store at that edge. The port is idle after it, with wait_n=1 and dq_oe=0.
- R10: After reset and after the fourth beat the port is idle: wait_n=1, dq_oe=0.
- R11: Only the low ARRAY_AW address bits (8 by default) select a word, so addresses that differ only above them reach the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Burst clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| addr | input | 22 | Word address, captured at the command edge |
| adv_n | input | 1 | Address strobe, active low |
| we_n | input | 1 | Write enable, active low, sampled with the strobe |
| oe_n | input | 1 | Output enable, active low |
| ub_n | input | 1 | Upper byte lane enable, active low |
| lb_n | input | 1 | Lower byte lane enable, active low |
| dq_in | input | 16 | Data from the host for write beats |
| dq_out | output | 16 | Data to the host for read beats |
| dq_oe | output | 1 | Pad driver enable for dq_out |
| wait_n | output | 1 | Latency indicator, low while data is not yet due |

## Verification
Every result is tied to the command edge k. wait_n is low when sampled after edges k through k+LATENCY-2 and high after k+LATENCY-1. A read word is checked just after edge k+LATENCY-1+b, the point where it must be stable for the host's sample at k+LATENCY+b. A write word is driven after edge k+LATENCY-1+b so that edge k+LATENCY+b takes it. The bench advances one edge at a time and samples 1 ns after each edge, so every check lands in the cycle computed from this count. A reference array in the bench, updated only on beats the requirements say are accepted, gives the expected read data. This also shows whether aborted and masked beats really left memory alone.

// File: rtl/psram_burst_pkg.sv
package psram_burst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_XFER  = 2'd2
    } port_state_e;

    localparam int BURST_WORDS = 4;
    localparam int BEAT_W      = $clog2(BURST_WORDS);

endpackage

// File: rtl/psram_cmd_fsm.sv
module psram_cmd_fsm
    import psram_burst_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int IDX_W  = 8,
    parameter int LAT    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              adv_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  beat_idx,
    output logic              beat_wr,
    output logic              beat_rd,
    output logic              wait_n
);

    localparam int CNT_W = (LAT < 2) ? 1 : $clog2(LAT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LAT - 1);
    localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(BURST_WORDS - 1);

    port_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [BEAT_W-1:0] beat_q, beat_d;
    logic              wr_q, wr_d;
    logic [IDX_W-1:0]  base_q, base_d;
    logic [BEAT_W-1:0] lane_off;
    logic              strobe;

    assign strobe = !cs_n && !adv_n;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        beat_d  = beat_q;
        wr_d    = wr_q;
        base_d  = base_q;
        if (cs_n) begin
            state_d = ST_IDLE;                      // deselect
        end else if (strobe) begin
            state_d = (LAT < 2) ? ST_XFER : ST_DELAY; // command start / restart
            cnt_d   = CNT_W'(1);
            beat_d  = '0;
            wr_d    = !we_n;
            base_d  = addr[IDX_W-1:0];
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                end
                ST_DELAY: begin
                    if (cnt_q == CNT_LAST) begin
                        state_d = ST_XFER;          // latency done
                        beat_d  = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                ST_XFER: begin
                    if (beat_q == BEAT_LAST) begin
                        state_d = ST_IDLE;          // burst end
                    end else begin
                        beat_d = beat_q + BEAT_W'(1); // beat advance
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            beat_q  <= '0;
            wr_q    <= 1'b0;
            base_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            beat_q  <= beat_d;
            wr_q    <= wr_d;
            base_q  <= base_d;
        end
    end

    // outputs
    always_comb begin
        lane_off = base_q[BEAT_W-1:0] + beat_q;
        beat_idx = {base_q[IDX_W-1:BEAT_W], lane_off};
        wait_n   = (state_q != ST_DELAY);
        beat_rd  = (state_q == ST_XFER) && !wr_q;
        beat_wr  = (state_q == ST_XFER) && wr_q && !cs_n && adv_n;
    end

    // R1: a strobe while selected always opens a burst at beat zero with the sampled direction
    p_cmd_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !adv_n) |=> (state_q != ST_IDLE && beat_q == '0 && wr_q == !$past(we_n)));

    // R3: beats advance by one per edge while no strobe or deselect intervenes
    p_beat_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER && beat_q != BEAT_LAST && !cs_n && adv_n)
        |=> (state_q == ST_XFER && beat_q == $past(beat_q) + BEAT_W'(1)));

    // R10: after the last beat the machine rests in idle
    p_burst_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER && beat_q == BEAT_LAST && !cs_n && adv_n) |=> (state_q == ST_IDLE));

    // R2: the latency count stays in the delay state until its last count
    p_delay_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DELAY && cnt_q != CNT_LAST && !cs_n && adv_n) |=> (state_q == ST_DELAY));

endmodule

// File: rtl/psram_word_store.sv
module psram_word_store #(
    parameter int IDX_W = 8,
    parameter int LANES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IDX_W-1:0]       idx,
    input  logic                   wr_en,
    input  logic [LANES-1:0]       lane_n,
    input  logic [LANES*8-1:0]     wdata,
    output logic [LANES*8-1:0]     rdata
);

    localparam int DEPTH = 1 << IDX_W;

    logic [LANES-1:0][7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) begin
                mem_q[w] <= '0;
            end
        end else if (wr_en) begin
            for (int l = 0; l < LANES; l++) begin
                if (!lane_n[l]) begin
                    mem_q[idx][l] <= wdata[l*8 +: 8];
                end
            end
        end
    end

    assign rdata = mem_q[idx];

    // R6: a write with every lane disabled leaves the addressed word unchanged
    p_masked_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (&lane_n)) |=> (rdata == $past(rdata) || idx != $past(idx)));

endmodule

// File: rtl/psram_burst_port.sv
module psram_burst_port #(
    parameter int ADDR_W   = 22,
    parameter int DATA_W   = 16,
    parameter int LATENCY  = 4,
    parameter int ARRAY_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              adv_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              wait_n
);

    localparam int LANES = DATA_W / 8;

    logic [ARRAY_AW-1:0] beat_idx;
    logic                beat_wr;
    logic                beat_rd;
    logic [DATA_W-1:0]   rd_word;
    logic [LANES-1:0]    lane_n;

    generate
        if (LANES == 2) begin : g_two_lanes
            assign lane_n = {ub_n, lb_n};
        end else begin : g_wide_lanes
            assign lane_n = {{(LANES-1){ub_n}}, lb_n};
        end
    endgenerate

    psram_cmd_fsm #(
        .ADDR_W (ADDR_W),
        .IDX_W  (ARRAY_AW),
        .LAT    (LATENCY)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .adv_n    (adv_n),
        .we_n     (we_n),
        .addr     (addr),
        .beat_idx (beat_idx),
        .beat_wr  (beat_wr),
        .beat_rd  (beat_rd),
        .wait_n   (wait_n)
    );

    psram_word_store #(
        .IDX_W (ARRAY_AW),
        .LANES (LANES)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx    (beat_idx),
        .wr_en  (beat_wr),
        .lane_n (lane_n),
        .wdata  (dq_in),
        .rdata  (rd_word)
    );

    always_comb begin
        dq_oe  = beat_rd && !cs_n && !oe_n;
        dq_out = dq_oe ? rd_word : '0;
    end

    // R7: the pad driver is only on for a selected, output-enabled beat
    p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!oe_n && !cs_n && wait_n));

    // R9: a deselect edge leaves the port idle
    p_deselect_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (wait_n && !dq_oe));

    // R2: wait is never low in a cycle that presents data
    p_wait_no_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wait_n) |-> !dq_oe);

endmodule

// File: tb/psram_burst_port_bench.sv
`timescale 1ns/1ps
module psram_burst_port_bench;

    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic [21:0] addr = '0;
    logic        adv_n = 1'b1;
    logic        we_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        ub_n = 1'b1;
    logic        lb_n = 1'b1;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic        dq_oe;
    logic        wait_n;

    int vectors = 0;
    int errors  = 0;
    logic [15:0] model [256];

    always #2 clk = ~clk;

    psram_burst_port #(.LATENCY(LAT)) u_psram_burst_port (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .addr   (addr),
        .adv_n  (adv_n),
        .we_n   (we_n),
        .oe_n   (oe_n),
        .ub_n   (ub_n),
        .lb_n   (lb_n),
        .dq_in  (dq_in),
        .dq_out (dq_out),
        .dq_oe  (dq_oe),
        .wait_n (wait_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] idx_of(input logic [21:0] a, input int b);
        logic [1:0] off;
        off = a[1:0] + 2'(b);
        return {a[7:2], off};
    endfunction

    // command edge; returns just after it
    task automatic issue(input logic [21:0] a, input bit wr);
        cs_n = 1'b0; adv_n = 1'b0; we_n = !wr; addr = a;
        step();
        adv_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic delay_phase(input string tag);
        for (int i = 0; i < LAT - 1; i++) begin
            chk({tag, " R2 wait low"}, wait_n, 1'b0);
            chk({tag, " R7 no drive in delay"}, dq_oe, 1'b0);
            step();
        end
        chk({tag, " R2 wait released"}, wait_n, 1'b1);
    endtask

    task automatic read_beats(input string tag, input logic [21:0] a, input int n, input bit drive);
        for (int b = 0; b < n; b++) begin
            if (drive) begin
                chk({tag, " R7 driving"}, dq_oe, 1'b1);
                chk({tag, " R3 R5 read word"}, dq_out, model[idx_of(a, b)]);
            end else begin
                chk({tag, " R7 oe high"}, dq_oe, 1'b0);
            end
            step();
        end
    endtask

    task automatic write_beats(input logic [21:0] a, input int n, input logic [15:0] seed,
                               input bit ub_off, input bit lb_off);
        for (int b = 0; b < n; b++) begin
            logic [15:0] d;
            logic [7:0]  i;
            d = seed + 16'(b * 16'h1111);
            i = idx_of(a, b);
            dq_in = d; ub_n = ub_off; lb_n = lb_off;
            chk("R7 no drive on write", dq_oe, 1'b0);
            step();
            if (!ub_off) model[i][15:8] = d[15:8];
            if (!lb_off) model[i][7:0] = d[7:0];
        end
        ub_n = 1'b1; lb_n = 1'b1; dq_in = 16'hdead;
    endtask

    task automatic check_idle(input string tag);
        chk({tag, " R10 wait high"}, wait_n, 1'b1);
        chk({tag, " R10 no drive"}, dq_oe, 1'b0);
    endtask

    task automatic t_reset();
        check_idle("reset");
    endtask

    task automatic t_write_read(input logic [21:0] a, input logic [15:0] seed, input string tag);
        issue(a, 1'b1);
        delay_phase({tag, " R4 write"});
        write_beats(a, 4, seed, 1'b0, 1'b0);
        check_idle({tag, " after write"});
        issue(a, 1'b0);
        delay_phase({tag, " R1 read"});
        read_beats({tag, " R3"}, a, 4, 1'b1);
        check_idle({tag, " after read"});
    endtask

    task automatic t_byte_lanes();
        issue(22'h000020, 1'b1);
        delay_phase("lanes");
        write_beats(22'h000020, 2, 16'haa55, 1'b1, 1'b0); // R6 low byte only
        write_beats(22'h000022, 2, 16'h3cc3, 1'b0, 1'b1); // R6 high byte only
        issue(22'h000020, 1'b0);
        delay_phase("lanes read");
        read_beats("R6 lane read", 22'h000020, 4, 1'b1);
        check_idle("lanes");
    endtask

    task automatic t_oe_off();
        oe_n = 1'b1;
        issue(22'h000010, 1'b0);
        delay_phase("oe off");
        read_beats("R7 oe off", 22'h000010, 4, 1'b0);
        oe_n = 1'b0;
        check_idle("oe off");
    endtask

    task automatic t_restart();
        // R8 restart during delay into a write
        issue(22'h000010, 1'b0);
        step();
        issue(22'h000050, 1'b1);
        delay_phase("R8 restart delay");
        write_beats(22'h000050, 4, 16'h5050, 1'b0, 1'b0);
        // R8 restart mid-read
        issue(22'h000010, 1'b0);
        delay_phase("R8 mid read");
        read_beats("R8 first part", 22'h000010, 2, 1'b1);
        issue(22'h000052, 1'b0);
        delay_phase("R8 new read");
        read_beats("R8 restarted read", 22'h000052, 4, 1'b1);
        check_idle("R8 read");
        // R8 restart mid-write: beat at the strobe edge is not stored
        issue(22'h000060, 1'b1);
        delay_phase("R8 mid write");
        write_beats(22'h000060, 2, 16'h6060, 1'b0, 1'b0);
        dq_in = 16'hbeef; ub_n = 1'b0; lb_n = 1'b0;
        issue(22'h000070, 1'b1);
        ub_n = 1'b1; lb_n = 1'b1;
        delay_phase("R8 new write");
        write_beats(22'h000070, 4, 16'h7070, 1'b0, 1'b0);
        issue(22'h000060, 1'b0);
        delay_phase("R8 check");
        read_beats("R8 aborted write kept old", 22'h000060, 4, 1'b1);
    endtask

    task automatic t_deselect();
        // R1 strobe while deselected starts nothing
        cs_n = 1'b1; adv_n = 1'b0; we_n = 1'b0; addr = 22'h000040;
        step();
        adv_n = 1'b1; we_n = 1'b1;
        chk("R1 strobe while deselected", wait_n, 1'b1);
        step();
        chk("R1 still idle", wait_n, 1'b1);
        // R9 deselect during delay
        issue(22'h000040, 1'b0);
        step();
        cs_n = 1'b1;
        step();
        chk("R9 wait released", wait_n, 1'b1);
        chk("R9 no drive", dq_oe, 1'b0);
        // R9 deselect mid-write: the deselect edge stores nothing
        issue(22'h000040, 1'b1);
        delay_phase("R9 write");
        write_beats(22'h000040, 1, 16'h4040, 1'b0, 1'b0);
        cs_n = 1'b1; dq_in = 16'hf00d; ub_n = 1'b0; lb_n = 1'b0;
        step();
        ub_n = 1'b1; lb_n = 1'b1;
        chk("R9 idle after deselect", wait_n, 1'b1);
        chk("R9 no drive after deselect", dq_oe, 1'b0);
        step();
        chk("R9 stays idle", wait_n, 1'b1);
        issue(22'h000040, 1'b0);
        delay_phase("R9 check");
        read_beats("R9 only first beat stored", 22'h000040, 4, 1'b1);
    endtask

    task automatic t_alias();
        issue(22'h200108, 1'b1);
        delay_phase("R11 alias write");
        write_beats(22'h200108, 4, 16'h1234, 1'b0, 1'b0);
        issue(22'h000008, 1'b0);
        delay_phase("R11 alias read");
        read_beats("R11 alias", 22'h000008, 4, 1'b1);
        check_idle("R11");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) model[i] = '0;
        #5;
        t_reset();
        rst_n = 1'b1;
        oe_n = 1'b0;
        step();
        t_reset();
        t_write_read(22'h000010, 16'h0102, "aligned");
        t_write_read(22'h000016, 16'h8001, "R5 wrap");
        issue(22'h000012, 1'b0);
        delay_phase("R5 wrap read");
        read_beats("R5 wrap read", 22'h000012, 4, 1'b1);
        t_byte_lanes();
        t_oe_off();
        t_restart();
        t_deselect();
        t_alias();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        vectors++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule